// File: doc/BRIEF.md
# Serial Flash Status and Deep Power-Down Command Front End

This block is the target-side command front end of a serial flash device. It uses SPI mode 0 only. It samples SCK, chip select and SI with the system clock. While chip select is low it collects the first eight SI bits of a transaction as an opcode.

In standby, the block acts on two opcodes:
- **Status read (D7h):** the block returns a status byte on SO, and keeps repeating it while chip select stays low.
- **Sleep (B9h):** the block arms a deep power-down request. That request takes effect only when chip select rises.

After a configurable entry delay the block reports that it is in deep power-down. In that state it ignores every opcode except wake (ABh), and it does not drive SO. A wake opcode returns the block to standby when chip select next rises.

The status byte is put together from sideband inputs supplied by the rest of the device: the busy flag, the result of the last page-to-buffer compare, the sector-protection state and the page-size setting. A fixed four-bit density code sits in the middle of the byte. The memory array and its operations live elsewhere.

Top module: `spi_status_pd_frontend`

## Requirements
- R1: After reset the block is in standby, `deep_pd_o` is 0 and `so_oe` is 0.
- R2: The status byte is laid out as follows:
  - bit 7 is 1 when `busy_i` is 0 (ready) and 0 when busy;
  - bit 6 equals `cmp_mismatch_i` (1 means at least one bit differed);
  - bits 5..2 always read 1001 and do not depend on any input;
  - bit 1 equals `protect_i`;
  - bit 0 equals `page256_i` (1 means 256-byte pages, 0 means 264-byte pages).
- R3: In standby, a complete opcode D7h (sent MSB first, sampled on SCK rising edges) makes the block drive SO with `so_oe` = 1. The block sends the status byte MSB first, updating SO after each SCK falling edge, starting with the falling edge that follows the eighth opcode rising edge.
- R4: While chip select stays low after D7h, the status byte repeats without a gap, byte after byte.
- R5: When chip select rises, `so_oe` is 0 from the next clock onward.
- R6: If chip select rises before eight opcode bits have arrived, the partial opcode is dropped and the power state does not change.
- R7: In standby, opcode B9h causes no state change while chip select stays low. After chip select rises, `deep_pd_o` becomes 1 no sooner than ENTRY_CYCLES and no later than ENTRY_CYCLES+SYNC_STAGES+2 clock cycles later.
- R8: While powered down (or entering power-down), every opcode other than ABh is ignored, including D7h and B9h, and `so_oe` stays 0.
- R9: While powered down, a complete ABh followed by a rise of chip select returns the block to standby (`deep_pd_o` = 0) within SYNC_STAGES+2 clock cycles. A partial ABh does not.
- R10: In standby, opcodes other than D7h and B9h (including ABh) have no effect: the state is unchanged and `so_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| busy_i | input | 1 | Device busy sideband flag |
| cmp_mismatch_i | input | 1 | Last page-to-buffer compare found a difference |
| protect_i | input | 1 | Sector protection enabled |
| page256_i | input | 1 | Binary 256-byte page size selected |
| so_o | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for SO (0 means high impedance) |
| deep_pd_o | output | 1 | Deep power-down reached |

## Verification
The bench checks several input patterns against the status byte. A design that swapped ready/busy polarity or moved the density code would return a wrong byte. A design that stopped after one byte would fail the second byte of a read.

The bench holds chip select low for a long time after B9h. A design that entered power-down at the opcode, rather than at the rise of chip select, would raise `deep_pd_o` early. The entry delay is checked against both its lower and its upper bound.

Truncated opcodes are sent for both B9h and ABh. A design that acted on partial bits would change state. Status-read, sleep and other opcodes are sent while powered down. A design that failed to ignore them would drive SO or leave the power-down state.

// File: rtl/spfe_pkg.sv
package spfe_pkg;
  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OP_STATUS = 8'hD7;
  localparam logic [OP_W-1:0] OP_SLEEP  = 8'hB9;
  localparam logic [OP_W-1:0] OP_WAKE   = 8'hAB;
  localparam logic [3:0] DENSITY_CODE   = 4'b1001;

  typedef enum logic [1:0] {
    PWR_STANDBY  = 2'd0,
    PWR_ENTERING = 2'd1,
    PWR_DEEP     = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic       ready;
    logic       mismatch;
    logic [3:0] density;
    logic       protect;
    logic       page_bin;
  } status_t;
endpackage

// File: rtl/spfe_sync.sv
module spfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_low,
  output logic si_s
);
  // bit 2: sck, bit 1: cs_n, bit 0: si
  logic [2:0] pipe [STAGES];
  logic       sck_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b010;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      pipe[0] <= {sck, cs_n, si};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sck_d <= pipe[STAGES-1][2];
      cs_d  <= pipe[STAGES-1][1];
    end
  end

  assign sck_rise = pipe[STAGES-1][2] & ~sck_d;
  assign sck_fall = ~pipe[STAGES-1][2] & sck_d;
  assign cs_rise  = pipe[STAGES-1][1] & ~cs_d;
  assign cs_low   = ~pipe[STAGES-1][1];
  assign si_s     = pipe[STAGES-1][0];
endmodule

// File: rtl/spfe_opcode_rx.sv
module spfe_opcode_rx
  import spfe_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sck_rise,
  input  logic            cs_low,
  input  logic            si_s,
  output logic            op_valid,
  output logic [OP_W-1:0] op_byte
);
  localparam int CNT_W = $clog2(OP_W);

  logic [OP_W-2:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic            done;

  always_ff @(posedge clk) begin
    if (rst || !cs_low) begin
      shreg    <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      op_valid <= 1'b0;
      if (rst) op_byte <= '0;
    end else begin
      op_valid <= 1'b0;
      if (sck_rise && !done) begin
        shreg <= {shreg[OP_W-3:0], si_s};
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(OP_W-1)) begin
          done     <= 1'b1;
          op_valid <= 1'b1;
          op_byte  <= {shreg, si_s};
        end
      end
    end
  end
endmodule

// File: rtl/spfe_power_ctrl.sv
module spfe_power_ctrl
  import spfe_pkg::*;
#(
  parameter int ENTRY_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_byte,
  input  logic            cs_rise,
  output pwr_state_e      state,
  output logic            tx_start
);
  localparam int DLY_W = $clog2(ENTRY_CYCLES + 1);

  logic [DLY_W-1:0] dly;
  logic             arm_sleep, arm_wake;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PWR_STANDBY;
      dly       <= '0;
      arm_sleep <= 1'b0;
      arm_wake  <= 1'b0;
    end else begin
      if (op_valid) begin
        if (state == PWR_STANDBY && op_byte == OP_SLEEP) arm_sleep <= 1'b1;
        if (state != PWR_STANDBY && op_byte == OP_WAKE)  arm_wake  <= 1'b1;
      end
      if (cs_rise && (arm_wake || arm_sleep)) begin
        if (arm_wake) begin
          state <= PWR_STANDBY;
        end else begin
          state <= PWR_ENTERING;
          dly   <= DLY_W'(ENTRY_CYCLES - 1);
        end
      end else if (state == PWR_ENTERING) begin
        if (dly == '0) state <= PWR_DEEP;
        else           dly   <= dly - 1'b1;
      end
      if (cs_rise) begin
        arm_sleep <= 1'b0;
        arm_wake  <= 1'b0;
      end
    end
  end

  assign tx_start = op_valid && (op_byte == OP_STATUS) && (state == PWR_STANDBY);
endmodule

// File: rtl/spfe_status_tx.sv
module spfe_status_tx
  import spfe_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    stop,
  input  logic    sck_fall,
  input  status_t status,
  output logic    so,
  output logic    oe
);
  localparam int IDX_W = $clog2(OP_W);

  logic [IDX_W-1:0] idx;
  status_t          snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      idx  <= IDX_W'(OP_W - 1);
      so   <= 1'b1;
      snap <= '0;
    end else if (stop) begin
      oe <= 1'b0;
    end else if (start) begin
      oe  <= 1'b1;
      idx <= IDX_W'(OP_W - 1);
    end else if (oe && sck_fall) begin
      if (idx == IDX_W'(OP_W - 1)) begin
        snap <= status;
        so   <= status[OP_W-1];
      end else begin
        so <= snap[idx];
      end
      idx <= idx - 1'b1;
    end
  end
endmodule

// File: rtl/spi_status_pd_frontend.sv
module spi_status_pd_frontend
  import spfe_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic busy_i,
  input  logic cmp_mismatch_i,
  input  logic protect_i,
  input  logic page256_i,
  output logic so_o,
  output logic so_oe,
  output logic deep_pd_o
);
  logic            sck_rise, sck_fall, cs_rise, cs_low, si_s;
  logic            op_valid, tx_start;
  logic [OP_W-1:0] op_byte;
  pwr_state_e      pwr_state;
  status_t         status;

  spfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .cs_low(cs_low), .si_s(si_s)
  );

  spfe_opcode_rx u_rx (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .cs_low(cs_low), .si_s(si_s),
    .op_valid(op_valid), .op_byte(op_byte)
  );

  spfe_power_ctrl #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_pwr (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte),
    .cs_rise(cs_rise), .state(pwr_state), .tx_start(tx_start)
  );

  always_comb begin
    status.ready    = ~busy_i;
    status.mismatch = cmp_mismatch_i;
    status.density  = DENSITY_CODE;
    status.protect  = protect_i;
    status.page_bin = page256_i;
  end

  spfe_status_tx u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .stop(cs_rise),
    .sck_fall(sck_fall), .status(status), .so(so_o), .oe(so_oe)
  );

  assign deep_pd_o = (pwr_state == PWR_DEEP);
endmodule

// File: rtl/spfe_checker.sv
module spfe_checker
  import spfe_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            so_oe,
  input logic            deep_pd_o,
  input logic            cs_rise,
  input logic            op_valid,
  input logic [OP_W-1:0] op_byte,
  input pwr_state_e      pwr_state
);
  // R7: deep power-down is only reached through the entry delay
  a_r7_entry_path: assert property (@(posedge clk) disable iff (rst)
    $rose(deep_pd_o) |-> $past(pwr_state) == PWR_ENTERING);

  // R7: a sleep opcode alone leaves standby untouched
  a_r7_wait_cs: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_byte == OP_SLEEP && pwr_state == PWR_STANDBY) |=> pwr_state == PWR_STANDBY);

  // R8: SO is never driven while powered down
  a_r8_quiet_pd: assert property (@(posedge clk) disable iff (rst)
    deep_pd_o |-> !so_oe);

  // R8: non-wake opcodes keep the block powered down
  a_r8_ignore_ops: assert property (@(posedge clk) disable iff (rst)
    (deep_pd_o && op_valid && op_byte != OP_WAKE) |=> deep_pd_o);

  // R5: chip select release stops the output driver
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !so_oe);
endmodule

bind spi_status_pd_frontend spfe_checker u_chk (
  .clk(clk), .rst(rst), .so_oe(so_oe), .deep_pd_o(deep_pd_o),
  .cs_rise(cs_rise), .op_valid(op_valid), .op_byte(op_byte), .pwr_state(pwr_state)
);

// File: tb/spi_status_pd_frontend_tb_top.sv
`timescale 1ns/1ps
module spi_status_pd_frontend_tb_top;
  localparam int ENTRY = 16;
  localparam int SYNC  = 2;
  localparam int HALF  = 8;

  typedef struct {
    logic       drive;
    logic [7:0] val;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic busy_i = 1'b0, cmp_mismatch_i = 1'b0, protect_i = 1'b0, page256_i = 1'b0;
  logic so_o, so_oe, deep_pd_o;

  int errors = 0;
  int checks = 0;
  int bit_no = 0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  spi_status_pd_frontend #(.SYNC_STAGES(SYNC), .ENTRY_CYCLES(ENTRY)) dut_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
    .busy_i(busy_i), .cmp_mismatch_i(cmp_mismatch_i), .protect_i(protect_i),
    .page256_i(page256_i), .so_o(so_o), .so_oe(so_oe), .deep_pd_o(deep_pd_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {~busy_i, cmp_mismatch_i, 4'b1001, protect_i, page256_i};
  endfunction

  task automatic cs_begin();
    @(negedge clk);
    bit_no = 0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic send_bits(input logic [7:0] op, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      si = op[7-b];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic clock_bytes(input int n);
    send_bits(8'h00, 0);
    for (int k = 0; k < n; k++) send_bits(8'h00, 8);
  endtask

  task automatic push(input logic drive, input logic [7:0] val, input string tag);
    item_t it;
    it.drive = drive; it.val = val; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: assembles response bytes and compares against queued items
  initial begin
    logic [7:0] cap = 8'h00;
    logic oe_all = 1'b1, oe_any = 1'b0;
    forever begin
      @(posedge sck);
      if (!cs_n) begin
        bit_no++;
        if (bit_no > 8) begin
          cap    = {cap[6:0], so_o};
          oe_all = oe_all & so_oe;
          oe_any = oe_any | so_oe;
          if ((bit_no - 8) % 8 == 0) begin
            if (exp_q.size() > 0) begin
              item_t it;
              it = exp_q.pop_front();
              if (it.drive) begin
                chk(oe_all, {it.tag, " so_oe"}, int'(oe_all), 1);
                chk(cap == it.val, {it.tag, " status byte"}, int'(cap), int'(it.val));
              end else begin
                chk(!oe_any, {it.tag, " SO not driven"}, int'(oe_any), 0);
              end
            end
            oe_all = 1'b1;
            oe_any = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    gap(5);
    rst = 1'b0;
    gap(2);
    // R1 reset state
    chk(deep_pd_o == 1'b0, "R1 deep_pd_o after reset", int'(deep_pd_o), 0);
    chk(so_oe == 1'b0, "R1 so_oe after reset", int'(so_oe), 0);

    // R2 R3 R4: status reads under several patterns, two bytes each
    busy_i = 0; cmp_mismatch_i = 0; protect_i = 0; page256_i = 0;
    push(1, 8'hA4, "R2 R3 pattern A"); push(1, 8'hA4, "R4 repeat A");
    cs_begin(); send_bits(8'hD7, 8); clock_bytes(2); cs_end();
    gap(4);
    chk(so_oe == 1'b0, "R5 so_oe after cs rise", int'(so_oe), 0);

    busy_i = 1; cmp_mismatch_i = 1; protect_i = 1; page256_i = 1;
    push(1, exp_status(), "R2 pattern B"); push(1, exp_status(), "R4 repeat B");
    push(1, exp_status(), "R4 third B");
    cs_begin(); send_bits(8'hD7, 8); clock_bytes(3); cs_end(); gap(4);

    busy_i = 0; cmp_mismatch_i = 1; protect_i = 0; page256_i = 1;
    push(1, 8'hE5, "R2 pattern C");
    cs_begin(); send_bits(8'hD7, 8); clock_bytes(1); cs_end(); gap(4);

    // R10: unknown opcode and wake in standby do nothing
    push(0, 8'h00, "R10 unknown opcode");
    cs_begin(); send_bits(8'h3C, 8); clock_bytes(1); cs_end(); gap(ENTRY + 8);
    chk(deep_pd_o == 1'b0, "R10 unknown keeps standby", int'(deep_pd_o), 0);
    push(0, 8'h00, "R10 wake in standby");
    cs_begin(); send_bits(8'hAB, 8); clock_bytes(1); cs_end(); gap(ENTRY + 8);
    chk(deep_pd_o == 1'b0, "R10 wake keeps standby", int'(deep_pd_o), 0);

    // R6: truncated sleep opcode
    cs_begin(); send_bits(8'hB9, 6); cs_end(); gap(ENTRY + 8);
    chk(deep_pd_o == 1'b0, "R6 partial sleep ignored", int'(deep_pd_o), 0);
    busy_i = 1; cmp_mismatch_i = 0; protect_i = 1; page256_i = 0;
    push(1, exp_status(), "R6 read after partial");
    cs_begin(); send_bits(8'hD7, 8); clock_bytes(1); cs_end(); gap(4);

    // R7: sleep waits for cs rise, then entry delay bounds
    cs_begin(); send_bits(8'hB9, 8);
    gap(ENTRY + 40);
    chk(deep_pd_o == 1'b0, "R7 no entry while cs low", int'(deep_pd_o), 0);
    cs_end();
    gap(ENTRY - 1);
    chk(deep_pd_o == 1'b0, "R7 entry not before delay", int'(deep_pd_o), 0);
    gap(SYNC + 3);
    chk(deep_pd_o == 1'b1, "R7 entry within bound", int'(deep_pd_o), 1);

    // R8: opcodes ignored while down
    push(0, 8'h00, "R8 status read while down");
    cs_begin(); send_bits(8'hD7, 8); clock_bytes(1); cs_end(); gap(8);
    chk(deep_pd_o == 1'b1, "R8 status read keeps down", int'(deep_pd_o), 1);
    cs_begin(); send_bits(8'hB9, 8); cs_end(); gap(ENTRY + 8);
    chk(deep_pd_o == 1'b1, "R8 sleep while down", int'(deep_pd_o), 1);
    cs_begin(); send_bits(8'h3C, 8); cs_end(); gap(8);
    chk(deep_pd_o == 1'b1, "R8 other opcode while down", int'(deep_pd_o), 1);

    // R9: partial wake ignored, full wake resumes
    cs_begin(); send_bits(8'hAB, 7); cs_end(); gap(8);
    chk(deep_pd_o == 1'b1, "R9 partial wake ignored", int'(deep_pd_o), 1);
    cs_begin(); send_bits(8'hAB, 8); cs_end();
    gap(SYNC + 2);
    chk(deep_pd_o == 1'b0, "R9 wake returns to standby", int'(deep_pd_o), 0);
    busy_i = 0; cmp_mismatch_i = 0; protect_i = 1; page256_i = 1;
    push(1, 8'hA7, "R9 read after wake");
    cs_begin(); send_bits(8'hD7, 8); clock_bytes(1); cs_end(); gap(4);

    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule